// File: doc/BRIEF.md
# Multi-Block Erase Sequencer

This block carries out a whole-array erase, one memory block at a time. When the command interface raises a start request, the block takes a snapshot of the protection state of every block. A block is protected if its lock bit is set. A boot block is also protected while the write-protect input is asserted. The block then walks the unprotected blocks from the lowest index to the highest. For each block it raises an erase request toward the per-block erase engine and waits for that engine to answer done or fail.

A failure ends the walk at once. The index of the failing block is kept for diagnosis. If no block may be erased, the block raises a lock error together with the erase error and issues no request. While the walk runs, a second start and any change of the protection inputs have no effect, so a run cannot be suspended or restarted. Busy, completion and the two error flags feed the status register. The erase engine itself and the command decoding sit outside this block.

Top module: `erase_sequencer`

## Requirements
- R1: Erase requests name only erasable blocks, each once, in strictly ascending index order, and no request appears after the last erasable block or outside a run.
- R2: Block b is erasable when lock_i[b] is 0 and, for a boot block (index below NUM_BOOT, boot blocks at the low end), wp_i is also 0; wp_i = 1 protects every boot block whatever its lock bit.
- R3: Once raised, erase_req_o stays high with erase_blk_o unchanged until erase_done_i or erase_fail_i is sampled high; the next request is raised only after a done.
- R4: busy_o goes high on the clock edge that accepts a start with at least one erasable block, stays high through every handshake, and falls within two cycles after the final done.
- R5: fin_o is 0 while busy_o is high and after an accepted start; it is set when a run ends (normal end, failure or lock error); on a normal end both error flags are 0.
- R6: erase_fail_i sampled high during a request ends the run on that edge: erase_req_o and busy_o fall, err_erase_o and fin_o are set, fail_idx_o takes the failing block index, and no further block is requested; fail takes precedence over done.
- R7: A start with no erasable block sets err_lock_o, err_erase_o and fin_o on the accepting edge, leaves busy_o low and issues no request.
- R8: While busy_o is high, start_i is ignored, and changes on lock_i and wp_i have no effect on which blocks the current run visits.
- R9: fail_idx_o and the flags hold their values until the next accepted start, which clears fail_idx_o to 0 and both error flags; done or fail pulses with no request pending are ignored.
- R10: After reset, busy_o, fin_o, erase_req_o, err_erase_o, err_lock_o and fail_idx_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start a whole-array erase (sampled when idle) |
| wp_i | input | 1 | Write-protect asserted: boot blocks protected |
| lock_i | input | NUM_BLOCKS | Per-block lock bits, 1 = locked |
| erase_req_o | output | 1 | Erase request to the per-block engine |
| erase_blk_o | output | IDX_W | Index of the block being erased |
| erase_done_i | input | 1 | Engine reports the requested block erased |
| erase_fail_i | input | 1 | Engine reports the requested block failed |
| busy_o | output | 1 | Run in progress |
| fin_o | output | 1 | Last run has ended |
| err_erase_o | output | 1 | Erase error flag |
| err_lock_o | output | 1 | Lock error flag (no block erasable) |
| fail_idx_o | output | IDX_W | Index of the block that failed |

## Verification
The hardest case to reach from the ports is a start request, or a change of the protection inputs, arriving in the middle of a run. The bench pulses start with an inverted lock mask and an inverted write-protect during the first handshake of some runs, then checks that the run still visits exactly the blocks of the original snapshot. It sweeps every lock mask with both write-protect values. For a set of masks it also injects a failure at each position in the run.

// File: rtl/erase_seq_pkg.sv
// Package: shared types for the erase sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package erase_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/erase_protect_mask.sv
// Module: erase_protect_mask
// Derives the erasable flag of every block from its lock bit and,
// for boot blocks, the write-protect input.
// Assumes: boot blocks occupy the lowest NUM_BOOT indices.
module erase_protect_mask #(
    parameter int NUM_BLOCKS = 8,
    parameter int NUM_BOOT   = 2
) (
    input  logic [NUM_BLOCKS-1:0] lock_i,
    input  logic                  wp_i,
    output logic [NUM_BLOCKS-1:0] erasable_o
);
    // one gate per block; boot blocks also see write-protect
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        if (b < NUM_BOOT) begin : g_boot
            assign erasable_o[b] = !lock_i[b] && !wp_i;
        end else begin : g_main
            assign erasable_o[b] = !lock_i[b];
        end
    end
endmodule

// File: rtl/erase_lowest_pick.sv
// Module: erase_lowest_pick
// Finds the lowest set bit of a vector and reports its index.
// Assumes: idx_o is meaningful only when any_o is high.
module erase_lowest_pick #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // scan downward so the lowest set bit wins
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/erase_sequencer.sv
// Module: erase_sequencer (top)
// Walks all erasable blocks in ascending order. It raises one erase
// request at a time and waits for done or fail. A failure stops the
// run, and an empty erasable set gives a lock error.
// Assumes: start_i is sampled only when idle; done/fail are sampled
// only while a request is pending; the protection state is captured
// at the accepted start.
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int NUM_BOOT   = 2,
    localparam int IDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  wp_i,
    input  logic [NUM_BLOCKS-1:0] lock_i,
    output logic                  erase_req_o,
    output logic [IDX_W-1:0]      erase_blk_o,
    input  logic                  erase_done_i,
    input  logic                  erase_fail_i,
    output logic                  busy_o,
    output logic                  fin_o,
    output logic                  err_erase_o,
    output logic                  err_lock_o,
    output logic [IDX_W-1:0]      fail_idx_o
);
    seq_state_t              state;
    logic [NUM_BLOCKS-1:0]   pend;
    logic [NUM_BLOCKS-1:0]   erasable;
    logic                    pick_any;
    logic [IDX_W-1:0]        pick_idx;

    erase_protect_mask #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .NUM_BOOT   (NUM_BOOT)
    ) u_mask (
        .lock_i     (lock_i),
        .wp_i       (wp_i),
        .erasable_o (erasable)
    );

    erase_lowest_pick #(
        .W     (NUM_BLOCKS),
        .IDX_W (IDX_W)
    ) u_pick (
        .vec_i (pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // run state machine: capture, issue, wait for handshake, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            pend        <= '0;
            erase_req_o <= 1'b0;
            erase_blk_o <= '0;
            busy_o      <= 1'b0;
            fin_o       <= 1'b0;
            err_erase_o <= 1'b0;
            err_lock_o  <= 1'b0;
            fail_idx_o  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        fail_idx_o <= '0;
                        if (|erasable) begin
                            pend        <= erasable;
                            busy_o      <= 1'b1;
                            fin_o       <= 1'b0;
                            err_erase_o <= 1'b0;
                            err_lock_o  <= 1'b0;
                            state       <= ST_ISSUE;
                        end else begin
                            fin_o       <= 1'b1;
                            err_erase_o <= 1'b1;
                            err_lock_o  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (pick_any) begin
                        erase_req_o <= 1'b1;
                        erase_blk_o <= pick_idx;
                        state       <= ST_WAIT;
                    end else begin
                        busy_o <= 1'b0;
                        fin_o  <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (erase_fail_i) begin
                        erase_req_o <= 1'b0;
                        busy_o      <= 1'b0;
                        fin_o       <= 1'b1;
                        err_erase_o <= 1'b1;
                        fail_idx_o  <= erase_blk_o;
                        pend        <= '0;
                        state       <= ST_IDLE;
                    end else if (erase_done_i) begin
                        erase_req_o       <= 1'b0;
                        pend[erase_blk_o] <= 1'b0;
                        state             <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/erase_sequencer_chk.sv
// Module: erase_sequencer_chk
// Checks the port protocol of erase_sequencer; attached by bind.
// Assumes: the same parameters as the top it is bound to.
module erase_sequencer_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             erase_req_o,
    input logic [IDX_W-1:0] erase_blk_o,
    input logic             erase_done_i,
    input logic             erase_fail_i,
    input logic             busy_o,
    input logic             fin_o,
    input logic             err_erase_o,
    input logic             err_lock_o,
    input logic [IDX_W-1:0] fail_idx_o
);
    logic             seen;
    logic [IDX_W-1:0] last_blk;

    // remember the last requested block of the current run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_blk <= '0;
        end else if (start_i && !busy_o) begin
            seen <= 1'b0;
        end else if (erase_req_o) begin
            seen     <= 1'b1;
            last_blk <= erase_blk_o;
        end
    end

    assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req_o) && seen |-> erase_blk_o > last_blk);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o && !erase_done_i && !erase_fail_i |=> erase_req_o && $stable(erase_blk_o));

    assert_req_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> busy_o);

    assert_fin_low_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fin_o);

    assert_fail_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o && erase_fail_i |=> !busy_o && !erase_req_o && err_erase_o && fail_idx_o == $past(erase_blk_o));

    assert_lock_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_lock_o |-> err_erase_o && !busy_o);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> !err_lock_o);
endmodule

bind erase_sequencer erase_sequencer_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .IDX_W      (IDX_W)
) u_chk (.*);

// File: tb/tb_erase_sequencer.sv
// Bench for erase_sequencer: sweeps every lock mask with both write-protect
// values, injects a failure at each run position, and probes ignored inputs.
module tb_erase_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 6;
    localparam int NBOOT      = 2;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          wp_i = 1'b0;
    logic [NB-1:0] lock_i = '0;
    logic          erase_done_i = 1'b0;
    logic          erase_fail_i = 1'b0;
    logic          erase_req_o;
    logic [IW-1:0] erase_blk_o;
    logic          busy_o, fin_o, err_erase_o, err_lock_o;
    logic [IW-1:0] fail_idx_o;

    int checks = 0;
    int failures = 0;

    erase_sequencer #(.NUM_BLOCKS(NB), .NUM_BOOT(NBOOT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wp_i(wp_i), .lock_i(lock_i),
        .erase_req_o(erase_req_o), .erase_blk_o(erase_blk_o),
        .erase_done_i(erase_done_i), .erase_fail_i(erase_fail_i),
        .busy_o(busy_o), .fin_o(fin_o), .err_erase_o(err_erase_o),
        .err_lock_o(err_lock_o), .fail_idx_o(fail_idx_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit can_erase(input logic [NB-1:0] lk, input logic w, input int b);
        return !lk[b] && !(b < NBOOT && w);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one full run: start, answer every request, check the outcome
    task automatic run(input logic [NB-1:0] lk, input logic w, input int fail_k, input bit poke);
        int n = 0;
        int k = 0;
        bit stopped = 0;
        for (int b = 0; b < NB; b++) if (can_erase(lk, w, b)) n++;
        @(negedge clk);
        lock_i = lk; wp_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(fail_idx_o == 0, "R9 fail_idx cleared by start", int'(fail_idx_o), 0);
        if (n == 0) begin
            chk(busy_o == 0, "R7 busy", int'(busy_o), 0);
            chk(err_lock_o == 1, "R7 err_lock", int'(err_lock_o), 1);
            chk(err_erase_o == 1, "R7 err_erase", int'(err_erase_o), 1);
            chk(fin_o == 1, "R5 fin on lock error", int'(fin_o), 1);
            repeat (3) begin
                @(negedge clk);
                chk(erase_req_o == 0, "R7 no request", int'(erase_req_o), 0);
            end
            return;
        end
        chk(busy_o == 1, "R4 busy after start", int'(busy_o), 1);
        chk(fin_o == 0, "R5 fin cleared", int'(fin_o), 0);
        chk(err_erase_o == 0 && err_lock_o == 0, "R9 flags cleared",
            int'({err_erase_o, err_lock_o}), 0);
        for (int b = 0; b < NB; b++) begin
            if (!stopped && can_erase(lk, w, b)) begin
                int g = 0;
                while (!erase_req_o && g < 10) begin @(negedge clk); g++; end
                chk(erase_req_o == 1, "R3 request raised", int'(erase_req_o), 1);
                chk(int'(erase_blk_o) == b, "R1/R2 block order", int'(erase_blk_o), b);
                if (poke && k == 0) begin
                    start_i = 1'b1; lock_i = ~lk; wp_i = ~w;
                end
                repeat ((b + k) % 3 + (poke && k == 0 ? 1 : 0)) begin
                    @(negedge clk);
                    start_i = 1'b0;
                    chk(erase_req_o && int'(erase_blk_o) == b, "R3 request held",
                        int'(erase_blk_o), b);
                    chk(busy_o == 1, "R8 busy through ignored start", int'(busy_o), 1);
                end
                if (k == fail_k) begin
                    erase_fail_i = 1'b1; erase_done_i = (b % 2 == 0);
                    @(negedge clk);
                    erase_fail_i = 1'b0; erase_done_i = 1'b0; start_i = 1'b0;
                    chk(busy_o == 0, "R6 busy drop", int'(busy_o), 0);
                    chk(erase_req_o == 0, "R6 request drop", int'(erase_req_o), 0);
                    chk(err_erase_o == 1, "R6 err_erase", int'(err_erase_o), 1);
                    chk(err_lock_o == 0, "R6 err_lock", int'(err_lock_o), 0);
                    chk(int'(fail_idx_o) == b, "R6 fail_idx", int'(fail_idx_o), b);
                    chk(fin_o == 1, "R5 fin on failure", int'(fin_o), 1);
                    repeat (3) begin
                        @(negedge clk);
                        chk(erase_req_o == 0, "R6 no later request", int'(erase_req_o), 0);
                    end
                    stopped = 1;
                end else begin
                    erase_done_i = 1'b1;
                    @(negedge clk);
                    erase_done_i = 1'b0; start_i = 1'b0;
                end
                k++;
            end
        end
        lock_i = lk; wp_i = w;
        if (!stopped) begin
            @(negedge clk);
            @(negedge clk);
            chk(busy_o == 0, "R4 busy falls", int'(busy_o), 0);
            chk(fin_o == 1, "R5 fin at end", int'(fin_o), 1);
            chk(err_erase_o == 0 && err_lock_o == 0, "R5 no error",
                int'({err_erase_o, err_lock_o}), 0);
            repeat (2) begin
                @(negedge clk);
                chk(erase_req_o == 0, "R1 no extra request", int'(erase_req_o), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R0 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && fin_o == 0 && erase_req_o == 0, "R10 reset outputs",
            int'({busy_o, fin_o, erase_req_o}), 0);
        chk(err_erase_o == 0 && err_lock_o == 0 && fail_idx_o == 0, "R10 reset flags",
            int'({err_erase_o, err_lock_o, fail_idx_o}), 0);
        // R2/R1 sweep: every lock mask, both write-protect values
        for (int m = 0; m < (1 << NB); m++) begin
            for (int w = 0; w < 2; w++) begin
                run(NB'(m), w[0], 99, (m % 5) == 1);
            end
        end
        // R6: failure at each position of a few runs, then R9 probes
        for (int s = 0; s < 3; s++) begin
            logic [NB-1:0] lk;
            lk = (s == 0) ? 6'h00 : (s == 1) ? 6'h15 : 6'h2A;
            for (int f = 0; f < NB; f++) begin
                run(lk, 1'b0, f, 1'b0);
                if (err_erase_o) begin
                    logic [IW-1:0] keep;
                    keep = fail_idx_o;
                    erase_done_i = 1'b1;
                    @(negedge clk);
                    erase_done_i = 1'b0; erase_fail_i = 1'b1;
                    @(negedge clk);
                    erase_fail_i = 1'b0;
                    @(negedge clk);
                    chk(fail_idx_o == keep, "R9 fail_idx held", int'(fail_idx_o), int'(keep));
                    chk(busy_o == 0 && erase_req_o == 0, "R9 stray handshake ignored",
                        int'({busy_o, erase_req_o}), 0);
                    chk(err_erase_o == 1, "R9 error held", int'(err_erase_o), 1);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule